// File: doc/BRIEF.md
# Iterative GCD Unit

This block finds the greatest common divisor of two unsigned W-bit numbers (W defaults to 16). It uses a subtract-and-swap loop and performs one step per clock. A producer hands over an operand pair on a valid/ready input channel. A consumer collects the result on a valid/ready output channel.

Inside the block, a datapath holds two working registers, A and B. Each has a small input multiplexer. The datapath also contains a subtractor, a less-than comparator and a zero detector. A three-state controller (idle, working, holding) reads two status flags from the datapath and returns register enables and multiplexer selects as a packed strobe struct. The result stays on the output until the consumer takes it. Only then does the unit accept new operands.

Top module: `gcd_iter`

## Requirements
- R1: After a synchronous active-high `rst`, `inReady` is 1 and `outValid` is 0. Asserting `rst` in the middle of a computation abandons it and returns the unit to this idle condition.
- R2: An operand pair is taken on a clock edge where `inValid` and `inReady` are both 1. In the cycle after that edge, `inReady` is 0.
- R3: `outData` equals the greatest common divisor of the accepted pair. The following cases hold: gcd(x,0)=x, gcd(0,y)=y and gcd(0,0)=0. For example, gcd(27,15)=3.
- R4: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` holds its value.
- R5: A result leaves on an edge where `outValid` and `outReady` are both 1. In the next cycle, `outValid` is 0 and `inReady` is 1.
- R6: `inReady` and `outValid` are never 1 in the same cycle.
- R7: After operands have been accepted, changes on `inA` and `inB` have no effect on the result.
- R8: Each working cycle does one of three things. If A<B, it swaps A and B. Otherwise, if B≠0, it sets A to A−B. Otherwise, it finishes. `outValid` therefore rises exactly S+1 clock edges after the accepting edge, where S is the number of swaps plus subtractions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair offered |
| inReady | output | 1 | Unit idle and able to take operands |
| inA | input | W | First operand |
| inB | input | W | Second operand |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| outData | output | W | Greatest common divisor |

## Verification
The properties assume several things about the block's inputs:
- `rst` is synchronous and held for at least one edge.
- `inValid` and `outReady` are clean levels at each rising edge.
- The producer needs to keep `inA` and `inB` valid only on the accepting edge.

The stimulus meets these conditions by changing every input on falling edges. It drops `inValid` right after the accepting edge and then scrambles the operand inputs. It waits a random number of cycles before offering operands and before raising `outReady`, which exercises the hold and release cases.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  typedef enum logic [1:0] {
    A_OPER = 2'd0,
    A_FROM_B = 2'd1,
    A_DIFF = 2'd2
  } selA_e;

  typedef enum logic {
    B_OPER = 1'b0,
    B_FROM_A = 1'b1
  } selB_e;

  typedef struct packed {
    logic enA;
    logic enB;
    selA_e selA;
    selB_e selB;
  } strobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WORK = 2'd1,
    ST_HOLD = 2'd2
  } state_e;

endpackage

// File: rtl/gcd_enreg.sv
module gcd_enreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/gcd_dpath.sv
module gcd_dpath
  import gcd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  strobes_t     strobe,
  input  logic [W-1:0] operA,
  input  logic [W-1:0] operB,
  output logic [W-1:0] result,
  output logic         bIsZero,
  output logic         aBelowB
);
  logic [W-1:0] regA, regB, nextA, nextB, diff;

  assign diff = regA - regB;

  always_comb begin
    case (strobe.selA)
      A_OPER:   nextA = operA;
      A_FROM_B: nextA = regB;
      A_DIFF:   nextA = diff;
      default:  nextA = '0;
    endcase
  end

  assign nextB = (strobe.selB == B_FROM_A) ? regA : operB;

  gcd_enreg #(.W(W)) uRegA (
    .clk(clk), .rst(rst), .en(strobe.enA), .d(nextA), .q(regA)
  );
  gcd_enreg #(.W(W)) uRegB (
    .clk(clk), .rst(rst), .en(strobe.enB), .d(nextB), .q(regB)
  );

  assign bIsZero = (regB == '0);
  assign aBelowB = (regA < regB);
  assign result  = regA;
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output logic     inReady,
  output logic     outValid,
  input  logic     outReady,
  input  logic     bIsZero,
  input  logic     aBelowB,
  output strobes_t strobe
);
  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    strobe    = '{enA: 1'b0, enB: 1'b0, selA: A_OPER, selB: B_OPER};
    inReady   = 1'b0;
    outValid  = 1'b0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        inReady    = 1'b1;
        strobe.enA = inValid;
        strobe.enB = inValid;
        if (inValid) stateNext = ST_WORK;
      end
      ST_WORK: begin
        if (aBelowB) begin
          strobe = '{enA: 1'b1, enB: 1'b1, selA: A_FROM_B, selB: B_FROM_A};
        end else if (!bIsZero) begin
          strobe.enA  = 1'b1;
          strobe.selA = A_DIFF;
        end else begin
          stateNext = ST_HOLD;
        end
      end
      ST_HOLD: begin
        outValid = 1'b1;
        if (outReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/gcd_iter.sv
module gcd_iter
  import gcd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output logic         inReady,
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  output logic         outValid,
  input  logic         outReady,
  output logic [W-1:0] outData
);
  strobes_t strobe;
  logic bIsZero, aBelowB;

  gcd_ctrl uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady),
    .bIsZero(bIsZero), .aBelowB(aBelowB), .strobe(strobe)
  );

  gcd_dpath #(.W(W)) uDpath (
    .clk(clk), .rst(rst), .strobe(strobe), .operA(inA), .operB(inB),
    .result(outData), .bIsZero(bIsZero), .aBelowB(aBelowB)
  );
endmodule

// File: rtl/gcd_iter_chk.sv
module gcd_iter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic         inReady,
  input logic         outValid,
  input logic         outReady,
  input logic [W-1:0] outData
);
  // R6
  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(inReady && outValid));
  // R2
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady);
  // R4
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
  // R5
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady) |=> (inReady && !outValid));
  // R1
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (inReady && !outValid));
endmodule

bind gcd_iter gcd_iter_chk #(.W(W)) uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData)
);

// File: tb/gcd_iter_test.sv
module gcd_iter_test;
  localparam int W = 16;
  localparam int NV = 12;
  localparam logic [3*W-1:0] VEC [NV] = '{
    {16'd27,    16'd15,    16'd3},
    {16'd15,    16'd27,    16'd3},
    {16'd48,    16'd18,    16'd6},
    {16'd17,    16'd5,     16'd1},
    {16'd100,   16'd0,     16'd100},
    {16'd0,     16'd35,    16'd35},
    {16'd0,     16'd0,     16'd0},
    {16'd65535, 16'd1,     16'd1},
    {16'd65535, 16'd65535, 16'd65535},
    {16'd1024,  16'd96,    16'd32},
    {16'd13,    16'd13,    16'd13},
    {16'd40000, 16'd30000, 16'd10000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, outReady = 1'b0;
  logic [W-1:0] inA = '0, inB = '0;
  logic inReady, outValid;
  logic [W-1:0] outData;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  gcd_iter #(.W(W)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inA(inA), .inB(inB), .outValid(outValid), .outReady(outReady),
    .outData(outData)
  );

  function automatic int stepCount(input logic [W-1:0] a0, input logic [W-1:0] b0);
    logic [W-1:0] a, b, t;
    int n;
    a = a0; b = b0; n = 0;
    while (1) begin
      if (a < b) begin t = a; a = b; b = t; end
      else if (b != 0) a = a - b;
      else break;
      n++;
    end
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] g);
    int cnt;
    logic [W-1:0] held;
    int waitIdle, waitRdy;
    waitIdle = $urandom_range(0, 3);
    repeat (waitIdle) @(negedge clk);
    check(inReady == 1'b1, "R2 idle ready", int'(inReady), 1);
    inValid = 1'b1; inA = a; inB = b;
    @(negedge clk);
    inValid = 1'b0;
    inA = W'($urandom); inB = W'($urandom); // R7: scrambled after accept
    check(inReady == 1'b0, "R2 busy after accept", int'(inReady), 0);
    cnt = 0;
    while (!outValid && cnt < 150000) begin
      if (inReady && outValid) check(1'b0, "R6", 1, 0);
      @(negedge clk);
      cnt++;
    end
    check(cnt == stepCount(a, b) + 1, "R8 latency", cnt, stepCount(a, b) + 1);
    check(outData == g, "R3/R7 result", int'(outData), int'(g));
    check(!inReady, "R6 exclusive", int'(inReady), 0);
    held = outData;
    waitRdy = $urandom_range(0, 3);
    repeat (waitRdy) begin
      @(negedge clk);
      check(outValid && outData == held, "R4 hold", int'(outData), int'(held));
    end
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(!outValid && inReady, "R5 release", int'(inReady), 1);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(inReady == 1'b1, "R1 ready after reset", int'(inReady), 1);
    check(outValid == 1'b0, "R1 no result after reset", int'(outValid), 0);

    for (int i = 0; i < NV; i++)
      runOne(VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], VEC[i][W-1:0]);

    // R1: reset in the middle of a computation
    inValid = 1'b1; inA = 16'd60000; inB = 16'd7;
    @(negedge clk);
    inValid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(inReady == 1'b1 && outValid == 1'b0, "R1 mid-run reset", int'(inReady), 1);

    // R3 after reset recovery
    runOne(16'd21, 16'd14, 16'd7);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule